// File: doc/BRIEF.md
# Four-Lane Tree Serializer and Deserializer

This block turns a group of four one-bit lanes into a single serial bit stream and turns such a stream back into four lanes. The transmit half is a two-level tree of 2:1 selectors. The selectors at the leaves pair adjacent lanes and switch on a half-rate phase bit. The root selector switches on the full-rate phase bit. Because of this tree, the lanes leave in bit-reversed order: lane 0, lane 2, lane 1, lane 3. The receive half steers each arriving bit through the mirror-image tree of 1:2 stages, so each bit lands back in its own lane. It also provides a quarter-rate frame clock.

Both halves are synchronous to one clock. They advance only on cycles where the bit-rate enable is high. Each half keeps its own phase counter, and both counters start at zero after reset. When the serial output is looped back into the serial input, the deserializer therefore recovers the transmitted groups with no training sequence. The tree depth is a parameter (`LVL`, giving `2**LVL` lanes). The default is two levels.

Top module: `tree_serdes4`

## Requirements
- R1: While `rst_n` is low, `ser_out`, `par_out`, `grp_valid` and `frm_clk` are all 0, and both phase counters are at slot 0.
- R2: The serializer samples all of `par_in` together, on the enabled edge that ends slot 3. Values that `par_in` takes during slots 0 to 2 have no effect on the serial stream.
- R3: In serial slot k (k = 0,1,2,3), `ser_out` carries the captured lane with index bit-reverse(k), giving the lane order 0, 2, 1, 3. The slot is set by the serializer phase, which advances by one on each enabled edge and wraps after 3.
- R4: `ser_out` is the root selector output. It shows slot k of the held group while the serializer phase equals k.
- R5: A bit on `ser_in` at the enabled edge of deserializer slot k is written to `par_out[bit-reverse(k)]`. `par_out` is updated only on the enabled edge of slot 3, with all four bits of the group.
- R6: `grp_valid` is high for exactly the one clock after the enabled edge of slot 3, and low otherwise.
- R7: `frm_clk` equals the high bit of the deserializer phase: it is 0 during slots 0 and 1 and 1 during slots 2 and 3, so it runs at one quarter of the bit rate.
- R8: With `ser_out` looped back to `ser_in`, a group captured on the edge ending slot 3 appears on `par_out` after the next four enabled edges, with no alignment step after reset.
- R9: In a clock where `bit_en` is 0, no state changes: `ser_out`, `par_out` and `frm_clk` hold their values and `grp_valid` is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-rate enable; one serial slot per enabled edge |
| par_in | input | 4 (2**LVL) | Parallel lanes to serialize |
| ser_out | output | 1 | Serial stream out |
| ser_in | input | 1 | Serial stream in |
| par_out | output | 4 (2**LVL) | Recovered parallel lanes |
| grp_valid | output | 1 | One-clock strobe when a new group is on `par_out` |
| frm_clk | output | 1 | Quarter-rate frame clock |

## Verification
`ser_out` depends on no extra register, so slot k is due in the clock where the phase equals k. The bench samples it at the falling edge before the enabled edge of that slot. `par_out` and `grp_valid` change on the fourth enabled edge of a group, and they are sampled at the next falling edge. In loopback, a group is therefore expected one full group (four enabled edges) after the edge that captured it. The bench works in whole groups and counts enabled edges itself, so every expected value is tied to a known slot. Idle cycles are checked for unchanged outputs before the next enabled edge.

// File: rtl/serdes4_pkg.sv
package serdes4_pkg;

  // Lane index carried in a serial slot: the slot number with its bits reversed.
  function automatic int unsigned lane_of_slot(input int unsigned slot, input int unsigned lvl);
    int unsigned r;
    r = 0;
    for (int unsigned b = 0; b < lvl; b++) begin
      r = (r << 1) | ((slot >> b) & 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/phase_ctr.sv
module phase_ctr #(
  parameter int LVL = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  output logic [LVL-1:0] phase,
  output logic           at_last
);

  localparam logic [LVL-1:0] LAST = {LVL{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  phase <= '0;
    else if (en) phase <= phase + 1'b1;
  end

  assign at_last = (phase == LAST);

endmodule

// File: rtl/ser_tree.sv
module ser_tree #(
  parameter int LVL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [LVL-1:0]    phase,
  input  logic              at_last,
  input  logic [(1<<LVL)-1:0] par_in,
  output logic              ser_out,
  output logic              load
);

  localparam int NCH = 1 << LVL;

  logic [NCH-1:0] hold;

  // Tree of 2:1 selectors. Leaves pair adjacent lanes on the slowest phase bit;
  // each level up uses a faster bit, and the root uses phase[0].
  function automatic logic tree_pick(input logic [NCH-1:0] v, input logic [LVL-1:0] ph);
    logic [NCH-1:0] cur;
    cur = v;
    for (int d = LVL - 1; d >= 0; d--) begin
      for (int j = 0; j < (1 << d); j++) begin
        cur[j] = ph[d] ? cur[2*j+1] : cur[2*j];
      end
    end
    return cur[0];
  endfunction

  assign load = en && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold <= '0;
    else if (load) hold <= par_in;
  end

  assign ser_out = tree_pick(hold, phase);

endmodule

// File: rtl/des_tree.sv
module des_tree #(
  parameter int LVL = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [LVL-1:0]      phase,
  input  logic                at_last,
  input  logic                ser_in,
  output logic [(1<<LVL)-1:0] par_out,
  output logic                grp_valid
);

  import serdes4_pkg::*;

  localparam int NCH = 1 << LVL;

  logic [NCH-1:0] slots;
  logic [NCH-1:0] grp_next;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_lane
      // Slot that routes into lane c (bit reversal is its own inverse).
      localparam int unsigned SL = lane_of_slot(c, LVL);
      assign grp_next[c] = (phase == LVL'(SL)) ? ser_in : slots[c];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  slots[c] <= 1'b0;
        else if (en) slots[c] <= grp_next[c];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out   <= '0;
      grp_valid <= 1'b0;
    end else begin
      grp_valid <= en && at_last;
      if (en && at_last) par_out <= grp_next;
    end
  end

endmodule

// File: rtl/tree_serdes4.sv
module tree_serdes4 #(
  parameter int LVL = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic [(1<<LVL)-1:0] par_in,
  output logic                ser_out,
  input  logic                ser_in,
  output logic [(1<<LVL)-1:0] par_out,
  output logic                grp_valid,
  output logic                frm_clk
);

  logic [LVL-1:0] ser_phase;
  logic [LVL-1:0] des_phase;
  logic           ser_last;
  logic           des_last;
  logic           ser_load;

  phase_ctr #(.LVL(LVL)) i_ser_ctr (
    .clk(clk), .rst_n(rst_n), .en(bit_en), .phase(ser_phase), .at_last(ser_last)
  );

  phase_ctr #(.LVL(LVL)) i_des_ctr (
    .clk(clk), .rst_n(rst_n), .en(bit_en), .phase(des_phase), .at_last(des_last)
  );

  ser_tree #(.LVL(LVL)) i_ser (
    .clk(clk), .rst_n(rst_n), .en(bit_en), .phase(ser_phase), .at_last(ser_last),
    .par_in(par_in), .ser_out(ser_out), .load(ser_load)
  );

  des_tree #(.LVL(LVL)) i_des (
    .clk(clk), .rst_n(rst_n), .en(bit_en), .phase(des_phase), .at_last(des_last),
    .ser_in(ser_in), .par_out(par_out), .grp_valid(grp_valid)
  );

  assign frm_clk = des_phase[LVL-1];

endmodule

// File: rtl/serdes4_chk.sv
module serdes4_chk #(
  parameter int LVL = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bit_en,
  input logic                ser_out,
  input logic [(1<<LVL)-1:0] par_out,
  input logic                grp_valid,
  input logic                frm_clk,
  input logic [LVL-1:0]      ser_phase,
  input logic [LVL-1:0]      des_phase
);

  localparam logic [LVL-1:0] LAST = {LVL{1'b1}};

  AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out)); // R9

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |=> !grp_valid); // R6

  AST_VALID_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> ($past(bit_en) && $past(des_phase) == LAST)); // R5

  AST_POUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid |-> $stable(par_out)); // R5

  AST_PHASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ser_phase == des_phase); // R8

  AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(frm_clk)); // R7

endmodule

bind tree_serdes4 serdes4_chk #(.LVL(LVL)) i_serdes4_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_out(ser_out), .par_out(par_out),
  .grp_valid(grp_valid), .frm_clk(frm_clk), .ser_phase(ser_phase), .des_phase(des_phase)
);

// File: tb/test_tree_serdes4.sv
`timescale 1ns/1ps
module test_tree_serdes4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [3:0] par_in = '0;
  logic       lb = 1'b1;
  logic       drv_ser = 1'b0;
  logic       ser_out, ser_in, grp_valid, frm_clk;
  logic [3:0] par_out;
  logic [3:0] last_grp = '0;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  assign ser_in = lb ? ser_out : drv_ser;

  tree_serdes4 #(.LVL(2)) i_tree_serdes4 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .par_in(par_in), .ser_out(ser_out),
    .ser_in(ser_in), .par_out(par_out), .grp_valid(grp_valid), .frm_clk(frm_clk)
  );

  function automatic int rev2(input int k);
    case (k)
      0: return 0;
      1: return 2;
      2: return 1;
      default: return 3;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Entered just after a falling edge, before the enabled edge of slot 0.
  task automatic run_frame(input logic [3:0] f, input bit gap);
    logic s_hold;
    logic fc_hold;
    logic [3:0] p_hold;
    for (int j = 0; j < 4; j++) begin
      par_in = (j == 1 || j == 2) ? ~f : f;            // R2: mid-group changes ignored
      check($sformatf("R3 slot %0d", j), ser_out, last_grp[rev2(j)]);
      check($sformatf("R7 slot %0d", j), frm_clk, (j >= 2));
      if (j > 0) check("R6 no strobe mid-group", grp_valid, 1'b0);
      if (gap) begin
        s_hold = ser_out; fc_hold = frm_clk; p_hold = par_out;
        bit_en = 1'b0;
        @(negedge clk);
        check("R9 ser_out held", ser_out, s_hold);
        check("R9 frm_clk held", frm_clk, fc_hold);
        check("R9 par_out held", par_out, p_hold);
        check("R9 no strobe idle", grp_valid, 1'b0);
        bit_en = 1'b1;
      end
      @(negedge clk);
    end
    check("R6 strobe after slot 3", grp_valid, 1'b1);
    check("R8 loopback group", par_out, last_grp);
    last_grp = f;
  endtask

  task automatic des_direct(input logic [3:0] s);
    logic [3:0] e;
    lb = 1'b0;
    for (int j = 0; j < 4; j++) begin
      drv_ser = s[j];
      @(negedge clk);
    end
    for (int k = 0; k < 4; k++) e[rev2(k)] = s[k];
    check($sformatf("R5 slot bits %b", s), par_out, e);
    check("R6 strobe direct", grp_valid, 1'b1);
    lb = 1'b1;
  endtask

  task automatic test_reset_mid();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 ser_out mid reset", ser_out, 1'b0);
    check("R1 par_out mid reset", par_out, 4'h0);
    check("R1 valid mid reset", grp_valid, 1'b0);
    check("R1 frm_clk mid reset", frm_clk, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    last_grp = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ser_out", ser_out, 1'b0);
    check("R1 par_out", par_out, 4'h0);
    check("R1 grp_valid", grp_valid, 1'b0);
    check("R1 frm_clk", frm_clk, 1'b0);
    rst_n = 1'b1;
    bit_en = 1'b1;
    // R3 R8: patterned then random groups in loopback
    run_frame(4'b0001, 1'b0);
    run_frame(4'b0100, 1'b0);
    run_frame(4'b0010, 1'b0);
    run_frame(4'b1000, 1'b0);
    for (int i = 0; i < 12; i++) run_frame(4'($urandom), 1'b0);
    // R9: idle cycles between every enabled edge
    for (int i = 0; i < 4; i++) run_frame(4'($urandom), 1'b1);
    run_frame(4'hA, 1'b0);
    // R5: one-hot slots straight into the deserializer
    des_direct(4'b0001);
    des_direct(4'b0010);
    des_direct(4'b0100);
    des_direct(4'b1000);
    des_direct(4'b0110);
    // R4 R1: reset in mid-group, phases restart at zero
    test_reset_mid();
    run_frame(4'h5, 1'b0);
    run_frame(4'hC, 1'b0);
    run_frame(4'h3, 1'b0);
    report();
  end

endmodule